// File: doc/BRIEF.md
# Packet Buffer Transmit Queue Manager

This block sits beside a network MAC and keeps track of a small pool of transmit buffers, counted in 256-byte pages and named by packet numbers. A host asks for room for a frame of a given byte length. Once enough pages and a free packet number are available, the block hands back the lowest free packet number and raises an allocation interrupt. The host fills the buffer through a separate data path, which is not part of this block. It then presents the packet number and issues an enqueue command. This places the number, not the frame data, in a transmit queue.

A MAC-side request/done/fail handshake consumes the queued numbers in order. It does so only while transmit is enabled and, in half-duplex mode, only while the deferral input allows it. On success the pages can be returned to the pool automatically. On failure transmit is disabled, the queue stops, and the failing number is exposed so the host can either free it or queue it again.

Top module: `pbq_txq_mgr`

## Requirements
- R1: An allocate command for L bytes needs max(1, ceil(L/256)) pages. When those pages and a free packet number exist, the lowest free packet number appears on `alloc_result_o` and status bit 0 (allocation done) is set.
- R2: An allocation that finds too few free pages stays pending with status bit 0 clear. It completes on its own once released pages make it fit.
- R3: An enqueue command pushes `pkt_num_i` into the transmit queue. If the queue is full, the command is dropped and the sticky status bit 3 (overflow) is set.
- R4: Queued numbers reach `mac_pkt_o` with `mac_req_o` high in enqueue order. This happens only while `txena_o` is 1 and never while both `half_duplex_i` and `defer_i` are 1. The request holds until done or fail.
- R5: With `auto_release_i` at 1, a successful completion returns the packet's pages and its number to the pool.
- R6: A successful completion that leaves the queue empty sets status bit 2 (queue drained).
- R7: A failed completion sets status bit 1 (transmit event), clears `txena_o`, and leaves the remaining queued numbers unsent. It shows the failed number on `tx_port_pkt_o` and does not release that packet.
- R8: A release command frees the packet named by `pkt_num_i`. Releasing a number that is not allocated changes nothing.
- R9: Writing 1 to a bit of `irq_clr_i` clears that status bit. `irq_o` is the OR of the status bits whose `irq_mask_i` bit is 1.
- R10: After reset all status bits, `irq_o`, `txena_o`, `mac_req_o` and `alloc_result_o` are 0.
- R11: With `auto_release_i` at 0, a successful completion sets status bit 1 and shows the number on `tx_port_pkt_o`, but keeps the packet allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_cmd_i | input | 1 | Allocate command strobe |
| alloc_len_i | input | LEN_W | Requested length in bytes |
| alloc_result_o | output | PKT_W | Packet number of the last finished allocation |
| pkt_num_i | input | PKT_W | Packet number used by enqueue and release |
| enq_cmd_i | input | 1 | Enqueue strobe |
| rel_cmd_i | input | 1 | Release strobe |
| txena_set_i | input | 1 | Set transmit enable |
| txena_clr_i | input | 1 | Clear transmit enable |
| txena_o | output | 1 | Transmit enable state |
| auto_release_i | input | 1 | Free pages on successful transmit |
| half_duplex_i | input | 1 | Half-duplex mode |
| defer_i | input | 1 | Deferral busy, blocks dispatch in half duplex |
| irq_clr_i | input | 4 | Write-1-to-clear status bits |
| irq_mask_i | input | 4 | Interrupt enables per status bit |
| irq_status_o | output | 4 | Status: 0 alloc, 1 tx event, 2 drained, 3 overflow |
| irq_o | output | 1 | Interrupt request |
| mac_req_o | output | 1 | Packet offered to the MAC |
| mac_pkt_o | output | PKT_W | Offered packet number |
| mac_done_i | input | 1 | MAC finished the packet successfully |
| mac_fail_i | input | 1 | MAC failed the packet |
| tx_port_pkt_o | output | PKT_W | Number of the last completed or failed packet |

## Verification
Allocation is tried in three situations: with room to spare, with too few pages, and after pages come back through a host release, through automatic release or through a bogus release. Together they separate rounding, lowest-number selection and pending behaviour. Transmission is tried with enable off, under half-duplex deferral, with a mid-queue failure followed by a retry, with and without automatic release, and with a queue driven past full. A scoreboard checks that each dispatched number matches enqueue order and that no dropped enqueue ever reaches the MAC.

// File: rtl/pbq_pkg.sv
package pbq_pkg;
   localparam int IRQ_W       = 4;
   localparam int IRQ_ALLOC   = 0;
   localparam int IRQ_TX      = 1;
   localparam int IRQ_TXEMPTY = 2;
   localparam int IRQ_OVF     = 3;

   typedef enum logic {TX_IDLE, TX_BUSY} tx_state_e;
endpackage

// File: rtl/pbq_irq.sv
module pbq_irq #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   input  logic [W-1:0] mask_i,
   output logic [W-1:0] status_o,
   output logic         irq_o
);
   logic [W-1:0] stat_q;

   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         stat_q[b] <= 1'b0;
         else if (set_i[b])  stat_q[b] <= 1'b1;
         else if (clr_i[b])  stat_q[b] <= 1'b0;
      end

      // R9: a clear with no competing set empties the bit
      a_r9_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
         clr_i[b] && !set_i[b] |=> !status_o[b]);
      // an event always lands in the status bit
      a_r9_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[b] |=> status_o[b]);
   end

   assign status_o = stat_q;
   assign irq_o    = |(stat_q & mask_i);
endmodule

// File: rtl/pbq_fifo.sv
module pbq_fifo #(
   parameter int W     = 4,
   parameter int DEPTH = 4,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] din_i,
   input  logic         pop_i,
   output logic [W-1:0] dout_o,
   output logic         full_o,
   output logic         empty_o
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pbq_fifo: DEPTH must be a power of two >= 2");
   end

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp_q, rp_q;

   always_ff @(posedge clk) begin
      if (push_i) mem[wp_q[AW-1:0]] <= din_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (push_i) wp_q <= wp_q + 1'b1;
         if (pop_i)  rp_q <= rp_q + 1'b1;
      end
   end

   assign dout_o  = mem[rp_q[AW-1:0]];
   assign empty_o = (wp_q == rp_q);
   assign full_o  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);

   // R3: the owner never writes into a full queue
   a_r3_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o);
   // R4: nothing is dispatched from an empty queue
   a_r4_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o);
endmodule

// File: rtl/pbq_alloc.sv
module pbq_alloc #(
   parameter int NUM_PKT     = 16,
   parameter int TOTAL_PAGES = 8,
   parameter int PAGE_SH     = 8,
   parameter int LEN_W       = 12,
   localparam int PKT_W      = $clog2(NUM_PKT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             rel_a_i,
   input  logic [PKT_W-1:0] rel_a_pkt_i,
   input  logic             rel_b_i,
   input  logic [PKT_W-1:0] rel_b_pkt_i,
   output logic             done_o,
   output logic [PKT_W-1:0] result_o
);
   localparam int CNT_W  = $clog2(TOTAL_PAGES + 1);
   localparam int NEED_W = LEN_W - PAGE_SH + 1;
   localparam int CMP_W  = (NEED_W > CNT_W) ? NEED_W : CNT_W;

   if (NUM_PKT < 2 || (NUM_PKT & (NUM_PKT - 1)) != 0) begin : g_bad_pkt
      $error("pbq_alloc: NUM_PKT must be a power of two >= 2");
   end
   if (LEN_W <= PAGE_SH) begin : g_bad_len
      $error("pbq_alloc: LEN_W must exceed PAGE_SH");
   end
   if (TOTAL_PAGES < 1) begin : g_bad_pages
      $error("pbq_alloc: TOTAL_PAGES must be positive");
   end

   logic [NUM_PKT-1:0] used_q;
   logic [CNT_W-1:0]   pages_q [NUM_PKT];
   logic [CNT_W-1:0]   free_q;
   logic               pending_q;
   logic [NEED_W-1:0]  need_q;
   logic [PKT_W-1:0]   result_q;

   // round the byte count up to whole pages, never less than one
   logic [LEN_W:0]    len_up;
   logic [NEED_W-1:0] need_raw, need_c;
   always_comb begin
      len_up   = {1'b0, len_i} + (LEN_W + 1)'((1 << PAGE_SH) - 1);
      need_raw = NEED_W'(len_up >> PAGE_SH);
      need_c   = (need_raw == '0) ? NEED_W'(1) : need_raw;
   end

   // lowest free packet number
   logic             have_pkt;
   logic [PKT_W-1:0] pick;
   always_comb begin
      have_pkt = 1'b0;
      pick     = '0;
      for (int i = NUM_PKT - 1; i >= 0; i--) begin
         if (!used_q[i]) begin
            have_pkt = 1'b1;
            pick     = PKT_W'(i);
         end
      end
   end

   logic fits, fire, hit_a, hit_b;
   logic [CNT_W-1:0] gain_a, gain_b;
   logic [CMP_W:0]   free_sum;
   always_comb begin
      fits   = CMP_W'(need_q) <= CMP_W'(free_q);
      fire   = pending_q && have_pkt && fits;
      hit_a  = rel_a_i && used_q[rel_a_pkt_i];
      hit_b  = rel_b_i && used_q[rel_b_pkt_i] && !(hit_a && rel_a_pkt_i == rel_b_pkt_i);
      gain_a = hit_a ? pages_q[rel_a_pkt_i] : '0;
      gain_b = hit_b ? pages_q[rel_b_pkt_i] : '0;
      free_sum = (CMP_W + 1)'(free_q) + (CMP_W + 1)'(gain_a) + (CMP_W + 1)'(gain_b)
               - (fire ? (CMP_W + 1)'(need_q) : '0);
   end

   for (genvar g = 0; g < NUM_PKT; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            used_q[g]  <= 1'b0;
            pages_q[g] <= '0;
         end else if (fire && pick == PKT_W'(g)) begin
            used_q[g]  <= 1'b1;
            pages_q[g] <= CNT_W'(need_q);
         end else if ((hit_a && rel_a_pkt_i == PKT_W'(g)) ||
                      (hit_b && rel_b_pkt_i == PKT_W'(g))) begin
            used_q[g]  <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         free_q    <= CNT_W'(TOTAL_PAGES);
         pending_q <= 1'b0;
         need_q    <= '0;
         result_q  <= '0;
      end else begin
         free_q <= CNT_W'(free_sum);
         if (fire) begin
            pending_q <= 1'b0;
            result_q  <= pick;
         end else if (req_i && !pending_q) begin
            pending_q <= 1'b1;
            need_q    <= need_c;
         end
      end
   end

   assign done_o   = fire;
   assign result_o = result_q;

   // R2: the page count never exceeds the pool
   a_r2_free_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      CMP_W'(free_q) <= CMP_W'(TOTAL_PAGES));
   // R1: a reported packet number is marked in use
   a_r1_result_used: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> used_q[result_o]);
   // R8: a host release of an allocated number frees it
   a_r8_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
      hit_b && !fire |=> !used_q[$past(rel_b_pkt_i)]);
endmodule

// File: rtl/pbq_txq_mgr.sv
module pbq_txq_mgr
   import pbq_pkg::*;
#(
   parameter int NUM_PKT     = 16,
   parameter int TOTAL_PAGES = 8,
   parameter int PAGE_SH     = 8,
   parameter int LEN_W       = 12,
   parameter int FIFO_DEPTH  = 4,
   localparam int PKT_W      = $clog2(NUM_PKT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_cmd_i,
   input  logic [LEN_W-1:0] alloc_len_i,
   output logic [PKT_W-1:0] alloc_result_o,
   input  logic [PKT_W-1:0] pkt_num_i,
   input  logic             enq_cmd_i,
   input  logic             rel_cmd_i,
   input  logic             txena_set_i,
   input  logic             txena_clr_i,
   output logic             txena_o,
   input  logic             auto_release_i,
   input  logic             half_duplex_i,
   input  logic             defer_i,
   input  logic [IRQ_W-1:0] irq_clr_i,
   input  logic [IRQ_W-1:0] irq_mask_i,
   output logic [IRQ_W-1:0] irq_status_o,
   output logic             irq_o,
   output logic             mac_req_o,
   output logic [PKT_W-1:0] mac_pkt_o,
   input  logic             mac_done_i,
   input  logic             mac_fail_i,
   output logic [PKT_W-1:0] tx_port_pkt_o
);
   tx_state_e        st_q;
   logic [PKT_W-1:0] cur_q, port_q;
   logic             txena_q;

   logic             q_full, q_empty, q_push, q_pop;
   logic [PKT_W-1:0] q_head;
   logic             alloc_done;
   logic             fin_ok, fin_bad, go;
   logic [IRQ_W-1:0] irq_set;

   always_comb begin
      q_push  = enq_cmd_i && !q_full;
      go      = (st_q == TX_IDLE) && txena_q && !q_empty && !(half_duplex_i && defer_i);
      q_pop   = go;
      fin_bad = (st_q == TX_BUSY) && mac_fail_i;
      fin_ok  = (st_q == TX_BUSY) && mac_done_i && !mac_fail_i;
      irq_set              = '0;
      irq_set[IRQ_ALLOC]   = alloc_done;
      irq_set[IRQ_TX]      = fin_bad || (fin_ok && !auto_release_i);
      irq_set[IRQ_TXEMPTY] = fin_ok && q_empty;
      irq_set[IRQ_OVF]     = enq_cmd_i && q_full;
   end

   pbq_fifo #(.W(PKT_W), .DEPTH(FIFO_DEPTH)) u_queue (
      .clk(clk), .rst_n(rst_n),
      .push_i(q_push), .din_i(pkt_num_i),
      .pop_i(q_pop), .dout_o(q_head),
      .full_o(q_full), .empty_o(q_empty)
   );

   pbq_alloc #(
      .NUM_PKT(NUM_PKT), .TOTAL_PAGES(TOTAL_PAGES),
      .PAGE_SH(PAGE_SH), .LEN_W(LEN_W)
   ) u_pool (
      .clk(clk), .rst_n(rst_n),
      .req_i(alloc_cmd_i), .len_i(alloc_len_i),
      .rel_a_i(fin_ok && auto_release_i), .rel_a_pkt_i(cur_q),
      .rel_b_i(rel_cmd_i), .rel_b_pkt_i(pkt_num_i),
      .done_o(alloc_done), .result_o(alloc_result_o)
   );

   pbq_irq #(.W(IRQ_W)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .set_i(irq_set), .clr_i(irq_clr_i), .mask_i(irq_mask_i),
      .status_o(irq_status_o), .irq_o(irq_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= TX_IDLE;
         cur_q   <= '0;
         port_q  <= '0;
         txena_q <= 1'b0;
      end else begin
         if (fin_bad)          txena_q <= 1'b0;
         else if (txena_set_i) txena_q <= 1'b1;
         else if (txena_clr_i) txena_q <= 1'b0;

         if (go) begin
            st_q  <= TX_BUSY;
            cur_q <= q_head;
         end else if (fin_ok || fin_bad) begin
            st_q   <= TX_IDLE;
            port_q <= cur_q;
         end
      end
   end

   assign txena_o       = txena_q;
   assign mac_req_o     = (st_q == TX_BUSY);
   assign mac_pkt_o     = cur_q;
   assign tx_port_pkt_o = port_q;

   // R7: a failure stops the queue and drops transmit enable
   a_r7_fail_stops: assert property (@(posedge clk) disable iff (!rst_n)
      fin_bad |=> !txena_o && !mac_req_o);
   // R4: a request is only raised while transmit is enabled
   a_r4_needs_txena: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mac_req_o) |-> $past(txena_o));
   // R4: an offered packet is held until the MAC answers
   a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mac_req_o && !mac_done_i && !mac_fail_i |=> mac_req_o && $stable(mac_pkt_o));
   // R4: deferral in half duplex blocks a new dispatch
   a_r4_defer_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      half_duplex_i && defer_i && !mac_req_o |=> !mac_req_o);
endmodule

// File: tb/pbq_txq_mgr_tb.sv
`timescale 1ns/1ps
module pbq_txq_mgr_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        alloc_cmd = 0, enq_cmd = 0, rel_cmd = 0;
   logic [11:0] alloc_len = '0;
   logic [3:0]  alloc_result, pkt_num = '0, mac_pkt, tx_port_pkt;
   logic        txena_set = 0, txena_clr = 0, txena;
   logic        auto_rel = 1, half_dup = 0, defer = 0;
   logic [3:0]  irq_clr = '0, irq_mask = 4'hF, irq_status;
   logic        irq, mac_req, mac_done = 0, mac_fail = 0;

   int n_chk = 0, n_fail = 0;
   int exp_q[$];
   bit req_prev = 0;

   always #10 clk = ~clk;

   pbq_txq_mgr u_dut (
      .clk(clk), .rst_n(rst_n),
      .alloc_cmd_i(alloc_cmd), .alloc_len_i(alloc_len), .alloc_result_o(alloc_result),
      .pkt_num_i(pkt_num), .enq_cmd_i(enq_cmd), .rel_cmd_i(rel_cmd),
      .txena_set_i(txena_set), .txena_clr_i(txena_clr), .txena_o(txena),
      .auto_release_i(auto_rel), .half_duplex_i(half_dup), .defer_i(defer),
      .irq_clr_i(irq_clr), .irq_mask_i(irq_mask), .irq_status_o(irq_status), .irq_o(irq),
      .mac_req_o(mac_req), .mac_pkt_o(mac_pkt), .mac_done_i(mac_done), .mac_fail_i(mac_fail),
      .tx_port_pkt_o(tx_port_pkt)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: every new dispatch must match the oldest expected number (R4)
   always @(negedge clk) begin
      if (rst_n && mac_req && !req_prev) begin
         if (exp_q.size() == 0) chk(1'b0, "R4 unexpected dispatch", int'(mac_pkt), -1);
         else begin
            int e;
            e = exp_q.pop_front();
            chk(int'(mac_pkt) == e, "R4 dispatch order", int'(mac_pkt), e);
         end
      end
      req_prev = mac_req;
   end

   task automatic do_alloc(input int len);
      @(negedge clk); alloc_len = 12'(len); alloc_cmd = 1;
      @(negedge clk); alloc_cmd = 0;
   endtask

   task automatic do_enq(input int p, input bit accept);
      if (accept) exp_q.push_back(p);
      @(negedge clk); pkt_num = 4'(p); enq_cmd = 1;
      @(negedge clk); enq_cmd = 0;
   endtask

   task automatic do_rel(input int p);
      @(negedge clk); pkt_num = 4'(p); rel_cmd = 1;
      @(negedge clk); rel_cmd = 0;
   endtask

   task automatic clr_irq(input logic [3:0] v);
      @(negedge clk); irq_clr = v;
      @(negedge clk); irq_clr = '0;
   endtask

   task automatic set_en();
      @(negedge clk); txena_set = 1;
      @(negedge clk); txena_set = 0;
   endtask

   task automatic clr_en();
      @(negedge clk); txena_clr = 1;
      @(negedge clk); txena_clr = 0;
   endtask

   task automatic wait_alloc(input int exp, input string req);
      int n = 0;
      while (!irq_status[0] && n < 20) begin @(negedge clk); n++; end
      chk(irq_status[0] == 1'b1, req, int'(irq_status[0]), 1);
      chk(int'(alloc_result) == exp, req, int'(alloc_result), exp);
      clr_irq(4'b0001);
   endtask

   task automatic expect_pending(input string req);
      repeat (6) @(negedge clk);
      chk(irq_status[0] == 1'b0, req, int'(irq_status[0]), 0);
   endtask

   task automatic mac_finish(input bit fail);
      int n = 0;
      @(negedge clk);
      while (!mac_req && n < 50) begin @(negedge clk); n++; end
      chk(mac_req == 1'b1, "R4 request seen", int'(mac_req), 1);
      repeat (2) @(negedge clk);
      if (fail) mac_fail = 1; else mac_done = 1;
      @(negedge clk); mac_fail = 0; mac_done = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10 reset state
      chk(irq_status == 4'h0, "R10 status", int'(irq_status), 0);
      chk(irq == 1'b0 && txena == 1'b0 && mac_req == 1'b0, "R10 irq/txena/req",
          int'({irq, txena, mac_req}), 0);
      chk(alloc_result == 4'h0, "R10 result", int'(alloc_result), 0);

      // R1: 300 bytes -> 2 pages, packet 0; R9 irq with mask
      do_alloc(300);
      repeat (2) @(negedge clk);
      chk(irq == 1'b1, "R9 masked irq high", int'(irq), 1);
      wait_alloc(0, "R1 first alloc");
      chk(irq_status[0] == 1'b0 && irq == 1'b0, "R9 w1c clears", int'(irq_status), 0);
      // R9: mask off -> status set but no irq; R1: 100 bytes -> 1 page, packet 1
      irq_mask = 4'hE;
      do_alloc(100);
      repeat (2) @(negedge clk);
      chk(irq_status[0] == 1'b1 && irq == 1'b0, "R9 masked off", int'(irq), 0);
      irq_mask = 4'hF;
      wait_alloc(1, "R1 second alloc");
      // R2: 1500 bytes -> 6 pages, only 5 free
      do_alloc(1500);
      expect_pending("R2 pending when short");
      do_rel(5);
      expect_pending("R8 bogus release no effect");
      do_rel(1);
      wait_alloc(1, "R2 R8 completes after release");
      // pool now full: pkt0 2 pages, pkt1 6 pages
      do_alloc(1);
      expect_pending("R2 pending at zero pages");

      // R4: no dispatch without txena
      do_enq(0, 1);
      repeat (4) @(negedge clk);
      chk(mac_req == 1'b0, "R4 txena off holds", int'(mac_req), 0);
      set_en();
      mac_finish(0);
      chk(irq_status[2] == 1'b1, "R6 drained", int'(irq_status[2]), 1);
      chk(irq_status[1] == 1'b0, "R5 no tx event on auto release", int'(irq_status[1]), 0);
      wait_alloc(0, "R5 auto release frees pages");
      clr_irq(4'hF);

      // R4 deferral, then R7 failure mid-queue (pkt0 1 page, pkt1 6, free 1)
      half_dup = 1; defer = 1;
      do_enq(1, 1);
      do_enq(0, 1);
      repeat (4) @(negedge clk);
      chk(mac_req == 1'b0, "R4 defer holds", int'(mac_req), 0);
      defer = 0;
      mac_finish(1);
      chk(irq_status[1] == 1'b1, "R7 tx event", int'(irq_status[1]), 1);
      chk(txena == 1'b0, "R7 txena cleared", int'(txena), 0);
      chk(int'(tx_port_pkt) == 1, "R7 failed number", int'(tx_port_pkt), 1);
      repeat (4) @(negedge clk);
      chk(mac_req == 1'b0, "R7 queue stopped", int'(mac_req), 0);
      clr_irq(4'hF);
      do_alloc(300);
      expect_pending("R7 failed packet kept");
      half_dup = 0;
      set_en();
      mac_finish(0);
      chk(irq_status[2] == 1'b1, "R6 drained after retry", int'(irq_status[2]), 1);
      wait_alloc(0, "R5 release feeds pending alloc");
      clr_irq(4'hF);

      // R11: success without auto release (pkt0 2, pkt1 6, free 0)
      auto_rel = 0;
      do_enq(1, 1);
      mac_finish(0);
      chk(irq_status[1] == 1'b1, "R11 tx event", int'(irq_status[1]), 1);
      chk(int'(tx_port_pkt) == 1, "R11 port number", int'(tx_port_pkt), 1);
      do_alloc(100);
      expect_pending("R11 packet kept");
      do_rel(1);
      wait_alloc(1, "R8 host release");
      clr_irq(4'hF);

      // R3: overflow on a full queue
      auto_rel = 1;
      clr_en();
      do_enq(3, 1); do_enq(2, 1); do_enq(1, 1); do_enq(0, 1);
      chk(irq_status[3] == 1'b0, "R3 no overflow yet", int'(irq_status[3]), 0);
      do_enq(7, 0);
      chk(irq_status[3] == 1'b1, "R3 overflow sticky", int'(irq_status[3]), 1);
      set_en();
      for (int i = 0; i < 4; i++) mac_finish(0);
      chk(irq_status[2] == 1'b1, "R6 drained after burst", int'(irq_status[2]), 1);
      repeat (6) @(negedge clk);
      chk(mac_req == 1'b0, "R3 dropped entry never sent", int'(mac_req), 0);
      chk(exp_q.size() == 0, "R3 scoreboard empty", exp_q.size(), 0);
      chk(irq_status[3] == 1'b1, "R3 overflow still set", int'(irq_status[3]), 1);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule